// File: doc/BRIEF.md
# Prescaled Match Timer Counter

A 16-bit timer/counter for a peripheral bus. It counts either every peripheral clock or the edges of a chosen external input. A programmable prescaler divides that tick stream first. Four match values are compared against the running count. On a match each one can raise a pending flag, return the count to zero, or halt counting. Each match also drives its own output pin, which can hold, clear, set or toggle. Any of the four pins can instead run as a pulse-width output, with match value 3 setting the period.

Software reaches every register through one word-wide bus. A write takes effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. Word addresses are: 0 flags, 1 control, 2 count, 3 prescale limit, 4 prescale count, 5 match actions, 6 to 9 match values 0 to 3, 10 output setup, 11 count source, 12 pulse-width enables.

A "step" is a clock edge on which the prescale counter has reached its limit while counting is enabled and a tick is present. The count changes only on steps. A match on channel k happens on a step whose count, before the edge, equals match value k.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `mat_out` is 0.
- R2: With run set and hold clear, the prescale counter (address 4) advances by one per tick. It returns to 0 on the tick where it equals the prescale limit (address 3), and that tick increments the count (address 2). So after k clock ticks in timer mode, starting from zero, the count is k/(limit+1) and the prescale counter is k mod (limit+1).
- R3: The count, the prescale limit, the prescale counter and the count-source register (address 11) read back the value last written when nothing else changes them.
- R4: Control register (address 1) bit 0 is run and bit 1 is hold. While hold is 1, the count and the prescale counter are forced to 0 on every edge.
- R5: Match-action register (address 5) bit 3k+1 enables "zero" for channel k. On a match with it set, the count becomes 0 instead of incrementing, giving a period of value+1 steps.
- R6: Bit 3k of address 5 enables the flag for channel k. A match then sets flag bit k of address 0, which stays set until a 1 is written to that bit. Writing 0 leaves it unchanged. Bits 7:4 read 0, and `irq` is high whenever any flag is set.
- R7: Bit 3k+2 of address 5 enables "halt" for channel k. A match with it set clears run and leaves the count at the match value, with the prescale counter at 0.
- R8: Output setup (address 10) holds the pin levels in bits 3:0, which are writable, and the 2-bit action of channel k in bits 5+2k:4+2k. The action codes are 0 hold, 1 clear, 2 set and 3 toggle, and each is applied to pin k on a match of channel k.
- R9: In address 11, bits 1:0 select the count source: 0 clock, 1 rising edges, 2 falling edges, 3 both edges. Bit 2 selects which of the two `ext_in` bits is used. The input passes through two synchronising flops before edge detection, the prescaler divides the counted edges, and the unselected input has no effect.
- R10: Bit k of address 12 puts pin k in pulse-width mode. If any such bit is set, a match on channel 3 returns the count to 0. On that step, each pulse-width pin goes low, or high when its own match value is 0. A match of its own channel sets the pin high, so with no prescale the pin is high exactly while the count exceeds its match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| ext_in | input | 2 | External count inputs |
| irq | output | 1 | High while any flag is pending |
| mat_out | output | 4 | Match output pins |

## Verification
A register write becomes visible on the edge that samples it, and a read is valid within the same cycle. With a prescale limit of p, the count after the run write is due p+1 edges later. A match result (flag, zero, halt, pin action) appears on the edge that leaves the matching count, one step after the count first shows the value. A change on an external input reaches the count on the third edge after it, once the two synchronising flops and the edge flop have been passed. The bench therefore drives and reads only at falling edges. It counts rising edges from the edge of the enabling write and predicts each value from that count, allowing extra settle cycles only where input latency applies.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2,
        SRC_BOTH = 2'd3
    } src_e;

    // one channel's match actions, flag in the lowest bit
    typedef struct packed {
        logic halt;
        logic zero;
        logic flag;
    } mctl_t;

    localparam int unsigned A_FLAGS = 0;
    localparam int unsigned A_CTRL  = 1;
    localparam int unsigned A_COUNT = 2;
    localparam int unsigned A_PRESC = 3;
    localparam int unsigned A_PCNT  = 4;
    localparam int unsigned A_MCTL  = 5;
    localparam int unsigned A_MV0   = 6;

    function automatic logic apply_act(input act_e a, input logic cur);
        case (a)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/mt_tick_src.sv
module mt_tick_src
    import match_timer_pkg::*;
#(
    parameter int N_IN  = 2,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  ext_in,
    input  logic [SEL_W-1:0] sel,
    input  src_e             mode,
    output logic             tick
);
    logic [N_IN-1:0] s1_q, s2_q;
    logic            prev_q;
    logic            cur;

    assign cur = s2_q[sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= ext_in;
            s2_q   <= s1_q;
            prev_q <= cur;
        end
    end

    always_comb begin
        case (mode)
            SRC_CLK:  tick = 1'b1;
            SRC_RISE: tick = cur & ~prev_q;
            SRC_FALL: tick = ~cur & prev_q;
            default:  tick = cur ^ prev_q;
        endcase
    end
endmodule

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] pcnt,
    output logic         wrap
);
    assign wrap = step && (pcnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr)  pcnt <= '0;
        else if (wr_en)  pcnt <= wr_val;
        else if (wrap)   pcnt <= '0;
        else if (step)   pcnt <= pcnt + W'(1);
    end
endmodule

// File: rtl/mt_match_chan.sv
module mt_match_chan
    import match_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] count,
    input  logic [W-1:0] mv,
    input  logic         wrap,
    input  act_e         act,
    input  logic         pwm,
    input  logic         period_rst,
    input  logic         wr_en,
    input  logic         wr_val,
    output logic         hit,
    output logic         out
);
    logic out_q;

    assign hit = wrap && (count == mv);
    assign out = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
        end else if (pwm) begin
            if (period_rst)  out_q <= (mv == '0);
            else if (hit)    out_q <= 1'b1;
            else if (wr_en)  out_q <= wr_val;
        end else if (hit) begin
            out_q <= apply_act(act, out_q);
        end else if (wr_en) begin
            out_q <= wr_val;
        end
    end
endmodule

// File: rtl/match_timer.sv
module match_timer
    import match_timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int N_MATCH = 4,
    parameter int N_IN    = 2,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    input  logic [N_IN-1:0]    ext_in,
    output logic               irq,
    output logic [N_MATCH-1:0] mat_out
);
    localparam int SEL_W    = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int MC_W     = 3 * N_MATCH;
    localparam int A_OUTCFG = A_MV0 + N_MATCH;
    localparam int A_MODE   = A_OUTCFG + 1;
    localparam int A_PWM    = A_MODE + 1;

    logic                   run_q, hold_q;
    logic [CNT_W-1:0]       count_q, presc_q, pcnt_q;
    logic [MC_W-1:0]        mctl_q;
    logic [2*N_MATCH-1:0]   act_q;
    src_e                   mode_q;
    logic [SEL_W-1:0]       sel_q;
    logic [N_MATCH-1:0]     pwm_q, flags_q;
    logic [CNT_W-1:0]       mv_q [N_MATCH];

    logic we_flags, we_ctrl, we_count, we_presc, we_pcnt, we_mctl;
    logic we_outcfg, we_mode, we_pwm;
    logic [N_MATCH-1:0] we_mv, hit, zero_mask, halt_mask, flag_en;
    logic tick, step, wrap, period_rst, any_zero, any_halt;

    assign we_flags  = bus_wr && (bus_addr == ADDR_W'(A_FLAGS));
    assign we_ctrl   = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
    assign we_count  = bus_wr && (bus_addr == ADDR_W'(A_COUNT));
    assign we_presc  = bus_wr && (bus_addr == ADDR_W'(A_PRESC));
    assign we_pcnt   = bus_wr && (bus_addr == ADDR_W'(A_PCNT));
    assign we_mctl   = bus_wr && (bus_addr == ADDR_W'(A_MCTL));
    assign we_outcfg = bus_wr && (bus_addr == ADDR_W'(A_OUTCFG));
    assign we_mode   = bus_wr && (bus_addr == ADDR_W'(A_MODE));
    assign we_pwm    = bus_wr && (bus_addr == ADDR_W'(A_PWM));

    mt_tick_src #(.N_IN(N_IN), .SEL_W(SEL_W)) u_src (
        .clk(clk), .rst(rst), .ext_in(ext_in), .sel(sel_q),
        .mode(mode_q), .tick(tick)
    );

    assign step = run_q && !hold_q && tick;

    mt_prescaler #(.W(CNT_W)) u_pre (
        .clk(clk), .rst(rst), .clr(hold_q), .wr_en(we_pcnt),
        .wr_val(bus_wdata), .step(step), .limit(presc_q),
        .pcnt(pcnt_q), .wrap(wrap)
    );

    for (genvar k = 0; k < N_MATCH; k++) begin : g_ch
        mctl_t mc;
        assign mc           = mctl_t'(mctl_q[3*k +: 3]);
        assign zero_mask[k] = mc.zero;
        assign halt_mask[k] = mc.halt;
        assign flag_en[k]   = mc.flag;
        assign we_mv[k]     = bus_wr && (bus_addr == ADDR_W'(A_MV0 + k));

        mt_match_chan #(.W(CNT_W)) u_ch (
            .clk(clk), .rst(rst), .count(count_q), .mv(mv_q[k]),
            .wrap(wrap), .act(act_e'(act_q[2*k +: 2])), .pwm(pwm_q[k]),
            .period_rst(period_rst), .wr_en(we_outcfg),
            .wr_val(bus_wdata[k]), .hit(hit[k]), .out(mat_out[k])
        );
    end

    assign period_rst = hit[N_MATCH-1] && (|pwm_q);
    assign any_zero   = (|(hit & zero_mask)) || period_rst;
    assign any_halt   = |(hit & halt_mask);
    assign irq        = |flags_q;

    always_ff @(posedge clk) begin
        if (rst || hold_q)  count_q <= '0;
        else if (we_count)  count_q <= bus_wdata;
        else if (wrap) begin
            if (any_zero)       count_q <= '0;
            else if (!any_halt) count_q <= count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            hold_q  <= 1'b0;
            presc_q <= '0;
            mctl_q  <= '0;
            act_q   <= '0;
            mode_q  <= SRC_CLK;
            sel_q   <= '0;
            pwm_q   <= '0;
            flags_q <= '0;
            for (int k = 0; k < N_MATCH; k++) mv_q[k] <= '0;
        end else begin
            if (we_ctrl) begin
                run_q  <= bus_wdata[0];
                hold_q <= bus_wdata[1];
            end
            if (wrap && any_halt) run_q <= 1'b0;
            if (we_presc)  presc_q <= bus_wdata;
            if (we_mctl)   mctl_q  <= bus_wdata[MC_W-1:0];
            if (we_outcfg) act_q   <= bus_wdata[N_MATCH +: 2*N_MATCH];
            if (we_mode) begin
                mode_q <= src_e'(bus_wdata[1:0]);
                sel_q  <= bus_wdata[2 +: SEL_W];
            end
            if (we_pwm) pwm_q <= bus_wdata[N_MATCH-1:0];
            for (int k = 0; k < N_MATCH; k++) begin
                if (we_mv[k]) mv_q[k] <= bus_wdata;
                if (hit[k] && flag_en[k])           flags_q[k] <= 1'b1;
                else if (we_flags && bus_wdata[k])  flags_q[k] <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_FLAGS))       bus_rdata = CNT_W'(flags_q);
        else if (bus_addr == ADDR_W'(A_CTRL))   bus_rdata = CNT_W'({hold_q, run_q});
        else if (bus_addr == ADDR_W'(A_COUNT))  bus_rdata = count_q;
        else if (bus_addr == ADDR_W'(A_PRESC))  bus_rdata = presc_q;
        else if (bus_addr == ADDR_W'(A_PCNT))   bus_rdata = pcnt_q;
        else if (bus_addr == ADDR_W'(A_MCTL))   bus_rdata = CNT_W'(mctl_q);
        else if (bus_addr == ADDR_W'(A_OUTCFG)) bus_rdata = CNT_W'({act_q, mat_out});
        else if (bus_addr == ADDR_W'(A_MODE))   bus_rdata = CNT_W'({sel_q, mode_q});
        else if (bus_addr == ADDR_W'(A_PWM))    bus_rdata = CNT_W'(pwm_q);
        for (int k = 0; k < N_MATCH; k++)
            if (bus_addr == ADDR_W'(A_MV0 + k)) bus_rdata = mv_q[k];
    end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
    import match_timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int N_MATCH = 4,
    parameter int ADDR_W  = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 irq,
    input logic [N_MATCH-1:0]   mat_out,
    input logic [CNT_W-1:0]     count_q,
    input logic [CNT_W-1:0]     pcnt_q,
    input logic [CNT_W-1:0]     presc_q,
    input logic                 run_q,
    input logic                 hold_q,
    input logic [N_MATCH-1:0]   pwm_q,
    input logic [2*N_MATCH-1:0] act_bits
);
    localparam int A_OC = A_MV0 + N_MATCH;

    // R4
    hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q |=> (count_q == '0 && pcnt_q == '0));

    // R2
    count_still_chk: assert property (@(posedge clk) disable iff (rst)
        ((!run_q || pcnt_q != presc_q) && !hold_q &&
         !(bus_wr && bus_addr == ADDR_W'(A_COUNT))) |=> $stable(count_q));

    // R7
    stopped_still_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !hold_q && !bus_wr) |=> ($stable(count_q) && $stable(pcnt_q)));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !(bus_wr && bus_addr == ADDR_W'(A_FLAGS))) |=> irq);

    for (genvar k = 0; k < N_MATCH; k++) begin : g_out
        // R8
        out_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (act_bits[2*k +: 2] == 2'd0 && !pwm_q[k] &&
             !(bus_wr && bus_addr == ADDR_W'(A_OC))) |=> $stable(mat_out[k]));
    end
endmodule

bind match_timer match_timer_chk #(
    .CNT_W(CNT_W), .N_MATCH(N_MATCH), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .irq(irq),
    .mat_out(mat_out), .count_q(count_q), .pcnt_q(pcnt_q), .presc_q(presc_q),
    .run_q(run_q), .hold_q(hold_q), .pwm_q(pwm_q), .act_bits(act_q)
);

// File: tb/match_timer_bench.sv
module match_timer_bench;
    localparam int A_FLAGS = 0, A_CTRL = 1, A_COUNT = 2, A_PRESC = 3, A_PCNT = 4;
    localparam int A_MCTL = 5, A_MV0 = 6, A_OUTCFG = 10, A_MODE = 11, A_PWM = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  ext_in = '0;
    logic        irq;
    logic [3:0]  mat_out;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    match_timer u_match_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
        .irq(irq), .mat_out(mat_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input int a, input int d);
        bus_addr  = 4'(a);
        bus_wdata = 16'(d);
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = 4'(a);
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic restart();
        wr(A_CTRL, 2);
        wr(A_CTRL, 1);
    endtask

    task automatic pulse(input int i);
        ext_in[i] = 1'b1;
        cyc(3);
        ext_in[i] = 1'b0;
        cyc(3);
    endtask

    function automatic int timer_count(input int k, input int p, input int m);
        return (k / (p + 1)) % (m + 1);
    endfunction

    task automatic edge_run(input int mode, input int p, input int i, input int n,
                            input int exp, input string req);
        int v;
        wr(A_CTRL, 0);
        wr(A_PRESC, p);
        wr(A_MODE, mode);
        restart();
        repeat (n) pulse(i);
        cyc(4);
        rd(A_COUNT, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int v;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a <= A_PWM; a++) begin
            rd(a, v);
            chk("R1 register", v, 0);
        end
        chk("R1 irq", int'(irq), 0);
        chk("R1 mat_out", int'(mat_out), 0);

        // R3 read back
        wr(A_COUNT, 16'h1234); rd(A_COUNT, v); chk("R3 count", v, 16'h1234);
        wr(A_PCNT, 7);         rd(A_PCNT, v);  chk("R3 pcnt", v, 7);
        wr(A_PRESC, 16'h55);   rd(A_PRESC, v); chk("R3 presc", v, 16'h55);
        wr(A_MODE, 5);         rd(A_MODE, v);  chk("R3 mode", v, 5);
        wr(A_MODE, 0);

        // R2 / R5 random prescale and period
        wr(A_MCTL, 2);
        for (int it = 0; it < 10; it++) begin
            int p, m, k;
            p = int'($urandom % 4);
            m = 1 + int'($urandom % 9);
            k = 1 + int'($urandom % 60);
            wr(A_CTRL, 0);
            wr(A_PRESC, p);
            wr(A_MV0, m);
            restart();
            cyc(k);
            rd(A_COUNT, v); chk("R2 R5 count", v, timer_count(k, p, m));
            rd(A_PCNT, v);  chk("R2 pcnt", v, k % (p + 1));
        end

        // R4 hold while running
        wr(A_CTRL, 3);
        cyc(3);
        rd(A_COUNT, v); chk("R4 count", v, 0);
        rd(A_PCNT, v);  chk("R4 pcnt", v, 0);
        wr(A_CTRL, 0);

        // R6 flags
        wr(A_PRESC, 0);
        wr(A_MV0, 3);
        wr(A_MCTL, 3);
        restart();
        cyc(10);
        wr(A_CTRL, 0);
        chk("R6 irq set", int'(irq), 1);
        rd(A_FLAGS, v); chk("R6 flags", v, 1);
        wr(A_FLAGS, 0);    rd(A_FLAGS, v); chk("R6 write0", v, 1);
        wr(A_FLAGS, 'hFE); rd(A_FLAGS, v); chk("R6 other bits", v, 1);
        wr(A_FLAGS, 1);    rd(A_FLAGS, v); chk("R6 clear", v, 0);
        chk("R6 irq clear", int'(irq), 0);

        // R7 halt on channel 1
        wr(A_PRESC, 1);
        wr(A_MV1_ADDR(), 5);
        wr(A_MCTL, 'h20);
        restart();
        cyc(40);
        rd(A_COUNT, v); chk("R7 count", v, 5);
        rd(A_CTRL, v);  chk("R7 run", v, 0);
        rd(A_PCNT, v);  chk("R7 pcnt", v, 0);

        // R8 output actions
        wr(A_PRESC, 0);
        wr(A_MCTL, 2);
        wr(A_MV0, 3);
        wr(A_MV0 + 1, 2);
        wr(A_MV0 + 2, 3);
        wr(A_MV0 + 3, 1);
        wr(A_OUTCFG, 'h788);
        chk("R8 preset", int'(mat_out), 8);
        restart();
        cyc(1); chk("R8 step1", int'(mat_out), 8);
        cyc(2); chk("R8 step3", int'(mat_out), 2);
        cyc(1); chk("R8 step4", int'(mat_out), 6);
        cyc(4); chk("R8 step8", int'(mat_out), 2);
        wr(A_CTRL, 0);
        rd(A_OUTCFG, v); chk("R8 readback", v, 'h782);

        // R9 external counting
        wr(A_MCTL, 0);
        wr(A_OUTCFG, 0);
        edge_run(1, 0, 0, 5, 5,  "R9 rising");
        edge_run(2, 0, 0, 5, 5,  "R9 falling");
        edge_run(3, 0, 0, 5, 10, "R9 both");
        edge_run(5, 0, 0, 3, 0,  "R9 unselected");
        edge_run(5, 0, 1, 2, 2,  "R9 select1");
        edge_run(1, 1, 0, 4, 2,  "R9 prescaled");

        // R10 pulse width
        wr(A_CTRL, 0);
        wr(A_MODE, 0);
        wr(A_PRESC, 0);
        wr(A_MV0 + 3, 9);
        wr(A_MV0, 4);
        wr(A_MV0 + 1, 0);
        wr(A_PWM, 3);
        rd(A_PWM, v); chk("R10 pwm reg", v, 3);
        restart();
        cyc(12);
        for (int i = 0; i < 20; i++) begin
            rd(A_COUNT, v);
            chk("R10 period", int'(v <= 9), 1);
            chk("R10 duty", int'(mat_out[0]), int'(v > 4));
            chk("R10 zero value", int'(mat_out[1]), 1);
            cyc(1);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    function automatic int A_MV1_ADDR();
        return A_MV0 + 1;
    endfunction
endmodule